// File: doc/BRIEF.md
# Framed Serial-to-Parallel Receiver

This block sits behind the receive pins of a one-way serial link. The far end sends a data line together with a forwarded bit clock. That clock also marks word boundaries by a distorted clock cycle. The receiver runs on a faster local system clock and oversamples both lines. It measures how long each clock level lasts and uses that to find the boundary markers. Between markers it shifts in one data bit on each rising edge of the forwarded clock. It then presents the recovered 22-bit word on a parallel port, together with an active-low word-clock pulse.

A word goes out only when exactly the expected number of bits has arrived between two consecutive markers, with no disturbance of the clock pattern in between. Any other span is dropped. The word clock then stays high, a one-cycle framing-error flag is raised, and the parallel port keeps the last good word. Downstream logic can latch the parallel port on the falling edge of the word clock.

Top module: `frame_rx_deser`

## Requirements
- R1: A valid word of WORD_BITS (22) bits appears on `wordOut`, with the first bit received at bit 0 and the last at bit 21.
- R2: A boundary marker is the forwarded clock held high for at least BIT_CYCLES system cycles, followed by a low level of at least BIT_CYCLES system cycles. A normal bit period is BIT_CYCLES cycles, split half high and half low.
- R3: Each data bit is the value of `rxData` at a rising edge of `rxClk`. The rising edge that opens a marker's long high level is not a data bit.
- R4: If fewer than WORD_BITS bits arrive between two consecutive markers, the word is discarded: `frameErr` is high for exactly one cycle and `wordClkN` stays high.
- R5: If more than WORD_BITS bits arrive between two consecutive markers, the word is discarded in the same way as in R4.
- R6: After reset, bits received before the first marker produce neither a word pulse nor a framing error at that first marker.
- R7: `wordOut` changes only when a valid word is delivered, and it holds its value through discarded words.
- R8: Each valid word drives `wordClkN` low for exactly PULSE_CYCLES system cycles. `wordOut` already holds the new word in the first low cycle. `wordClkN` is high otherwise.
- R9: During and right after reset, `wordOut` is zero, `wordClkN` is high and `frameErr` is low.
- R10: A long high level followed by a normal-length low level (a broken marker) invalidates the word in progress, even if the bit count is otherwise correct.
- R11: A long low level that does not follow a long high level invalidates the word in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxClk | input | 1 | Forwarded bit clock carrying boundary markers (asynchronous) |
| rxData | input | 1 | Serial data line (asynchronous) |
| wordOut | output | WORD_BITS | Last valid recovered word |
| wordClkN | output | 1 | Active-low word-clock pulse, one per valid word |
| frameErr | output | 1 | One-cycle pulse when a span between markers is discarded |

## Verification
The main function is tried with several kinds of word: a single one walking across all 22 positions, a single zero walking across all positions, all zeros, all ones, the two alternating patterns, and a set of arithmetic pseudo-random words. The walking patterns tell apart bit order and off-by-one shifting errors. The uniform and alternating words expose stuck or swapped bits. Spans of 0, 1, 21 and 23 bits check the count decision on both sides of 22. A broken marker and a stray long low level, each carrying exactly 22 bits, show that the decision rests on framing integrity and not just on the bit count.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Strobes issued by the control section to the word datapath.
  typedef struct packed {
    logic capture;   // rising edge of forwarded clock: latch data bit
    logic commit;    // end of a normal high level: shift latched bit in
    logic boundary;  // complete marker recognized
    logic corrupt;   // clock pattern broken inside the current span
  } rxStrobe_t;

endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int BIT_CYCLES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxClk,
  input  logic              rxData,
  output rxf_pkg::rxStrobe_t strobe,
  output logic              sampleBit
);
  import rxf_pkg::*;

  localparam int LONG_RUN = BIT_CYCLES;
  localparam int RUN_W    = $clog2(LONG_RUN + 1);

  // Synchronizer: both lines travel through identical stages so that
  // their relative timing is preserved.
  logic [1:0] syncPipe [SYNC_STAGES];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncPipe[s] <= 2'b00;
          else        syncPipe[s] <= {rxClk, rxData};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncPipe[s] <= 2'b00;
          else        syncPipe[s] <= syncPipe[s-1];
        end
      end
    end
  endgenerate

  logic clkS, dataS, clkD;
  assign clkS  = syncPipe[SYNC_STAGES-1][1];
  assign dataS = syncPipe[SYNC_STAGES-1][0];

  logic [RUN_W-1:0] runCnt;
  logic             longHigh;
  logic             riseEv, fallEv, lowLongEv, longHighEnd;

  always_comb begin
    riseEv      = clkS & ~clkD;
    fallEv      = ~clkS & clkD;
    lowLongEv   = ~clkS & ~clkD & (runCnt == RUN_W'(LONG_RUN - 1));
    longHighEnd = fallEv & (runCnt >= RUN_W'(LONG_RUN));
  end

  // Level run-length counter, saturating at the long threshold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkD   <= 1'b0;
      runCnt <= '0;
    end else begin
      clkD <= clkS;
      if (clkS != clkD)
        runCnt <= RUN_W'(1);
      else if (runCnt < RUN_W'(LONG_RUN))
        runCnt <= runCnt + RUN_W'(1);
    end
  end

  // Remembers that the last high level was a marker-length high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      longHigh <= 1'b0;
    else if (longHighEnd)
      longHigh <= 1'b1;
    else if (lowLongEv || riseEv)
      longHigh <= 1'b0;
  end

  always_comb begin
    strobe.capture  = riseEv;
    strobe.commit   = fallEv & ~longHighEnd;
    strobe.boundary = lowLongEv & longHigh;
    strobe.corrupt  = (lowLongEv & ~longHigh) | (riseEv & longHigh);
    sampleBit       = dataS;
  end

endmodule

// File: rtl/rxf_dpath.sv
module rxf_dpath #(
  parameter int WORD_BITS    = 22,
  parameter int PULSE_CYCLES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  rxf_pkg::rxStrobe_t strobe,
  input  logic               sampleBit,
  output logic [WORD_BITS-1:0] wordOut,
  output logic               wordClkN,
  output logic               frameErr
);
  import rxf_pkg::*;

  localparam int CNT_W   = $clog2(WORD_BITS + 1);
  localparam int PULSE_W = $clog2(PULSE_CYCLES + 1);

  logic                 pendBit;
  logic [WORD_BITS-1:0] shiftReg;
  logic [CNT_W-1:0]     bitCnt;
  logic                 spanBad;
  logic                 spanActive;
  logic [PULSE_W-1:0]   pulseCnt;
  logic                 wordGood;
  logic                 fullWord;

  always_comb begin
    fullWord = (bitCnt == CNT_W'(WORD_BITS));
    wordGood = strobe.boundary & spanActive & fullWord & ~spanBad;
  end

  // Bit capture and shifting (first bit ends up at bit 0).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendBit  <= 1'b0;
      shiftReg <= '0;
    end else begin
      if (strobe.capture)
        pendBit <= sampleBit;
      if (strobe.commit && !fullWord)
        shiftReg <= {pendBit, shiftReg[WORD_BITS-1:1]};
    end
  end

  // Span bookkeeping between markers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt     <= '0;
      spanBad    <= 1'b0;
      spanActive <= 1'b0;
    end else if (strobe.boundary) begin
      bitCnt     <= '0;
      spanBad    <= 1'b0;
      spanActive <= 1'b1;
    end else begin
      if (strobe.commit) begin
        if (fullWord) spanBad <= 1'b1;
        else          bitCnt  <= bitCnt + CNT_W'(1);
      end
      if (strobe.corrupt)
        spanBad <= 1'b1;
    end
  end

  // Output word, word-clock pulse and framing error.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wordOut  <= '0;
      pulseCnt <= '0;
      frameErr <= 1'b0;
    end else begin
      frameErr <= strobe.boundary & spanActive & ~wordGood;
      if (wordGood) begin
        wordOut  <= shiftReg;
        pulseCnt <= PULSE_W'(PULSE_CYCLES);
      end else if (pulseCnt != '0) begin
        pulseCnt <= pulseCnt - PULSE_W'(1);
      end
    end
  end

  assign wordClkN = (pulseCnt == '0);

endmodule

// File: rtl/frame_rx_deser.sv
module frame_rx_deser #(
  parameter int WORD_BITS    = 22,
  parameter int BIT_CYCLES   = 8,
  parameter int PULSE_CYCLES = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxClk,
  input  logic                 rxData,
  output logic [WORD_BITS-1:0] wordOut,
  output logic                 wordClkN,
  output logic                 frameErr
);
  import rxf_pkg::*;

  rxStrobe_t strobe;
  logic      sampleBit;

  rxf_ctrl #(
    .BIT_CYCLES (BIT_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rxClk    (rxClk),
    .rxData   (rxData),
    .strobe   (strobe),
    .sampleBit(sampleBit)
  );

  rxf_dpath #(
    .WORD_BITS   (WORD_BITS),
    .PULSE_CYCLES(PULSE_CYCLES)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .sampleBit(sampleBit),
    .wordOut  (wordOut),
    .wordClkN (wordClkN),
    .frameErr (frameErr)
  );

endmodule

// File: rtl/frame_rx_deser_chk.sv
module frame_rx_deser_chk #(
  parameter int WORD_BITS    = 22,
  parameter int PULSE_CYCLES = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [WORD_BITS-1:0] wordOut,
  input logic                 wordClkN,
  input logic                 frameErr,
  input rxf_pkg::rxStrobe_t   strobe
);

  localparam int LOW_W = $clog2(PULSE_CYCLES + 2) + 1;
  logic [LOW_W-1:0] lowCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lowCnt <= '0;
    else if (!wordClkN) lowCnt <= lowCnt + LOW_W'(1);
    else               lowCnt <= '0;
  end

  // R8: each low pulse lasts exactly PULSE_CYCLES cycles
  a_r8_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wordClkN) |-> (lowCnt == LOW_W'(PULSE_CYCLES)));

  // R4: a word pulse only follows a recognized marker
  a_r4_pulse_after_marker: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wordClkN) |-> $past(strobe.boundary));

  // R4: framing error only follows a recognized marker
  a_r4_err_after_marker: assert property (@(posedge clk) disable iff (!rst_n)
    frameErr |-> $past(strobe.boundary));

  // R4: error never coincides with a word delivery
  a_r4_err_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frameErr |-> !$fell(wordClkN));

  // R4: error flag lasts a single cycle
  a_r4_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    frameErr |=> !frameErr);

  // R7: the output word moves only together with a new pulse
  a_r7_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wordOut) |-> $fell(wordClkN));

  // R9: idle outputs at reset release
  a_r9_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wordClkN && !frameErr && wordOut == '0));

endmodule

bind frame_rx_deser frame_rx_deser_chk #(
  .WORD_BITS   (WORD_BITS),
  .PULSE_CYCLES(PULSE_CYCLES)
) chk (.*);

// File: tb/frame_rx_deser_test.sv
module frame_rx_deser_test;
  localparam int WB   = 22;
  localparam int BC   = 8;
  localparam int PC   = 3;
  localparam int HALF = BC / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxClk = 1'b0;
  logic rxData = 1'b0;
  logic [WB-1:0] wordOut;
  logic wordClkN, frameErr;

  frame_rx_deser #(.WORD_BITS(WB), .BIT_CYCLES(BC), .PULSE_CYCLES(PC)) uut (
    .clk(clk), .rst_n(rst_n), .rxClk(rxClk), .rxData(rxData),
    .wordOut(wordOut), .wordClkN(wordClkN), .frameErr(frameErr)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int pulses = 0, errPulses = 0, lowRun = 0;
  logic [WB-1:0] lastWord = '0;
  logic prevN = 1'b1;
  bit finished = 0;

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (prevN && !wordClkN) begin
        pulses++;
        lastWord = wordOut;
      end
      if (!wordClkN) lowRun++;
      else if (!prevN) begin
        checks++;
        if (lowRun != PC) begin
          errors++;
          $display("FAIL R8 pulse width actual %0d expected %0d", lowRun, PC);
        end
        lowRun = 0;
      end
      if (frameErr) errPulses++;
      prevN = wordClkN;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    rxClk  = 1'b0;
    rxData = b;
    idle(HALF);
    rxClk = 1'b1;
    idle(HALF);
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) sendBit(v[i % 32]);
  endtask

  task automatic sendMarker();
    rxClk = 1'b0;
    idle(HALF);
    rxClk = 1'b1;
    idle(2 * BC);
    rxClk = 1'b0;
    idle(2 * BC);
    idle(6);
  endtask

  // R1 R3 R8: a full word must come out intact, with one pulse and no error
  task automatic goodWord(input logic [WB-1:0] v);
    int p0, e0;
    p0 = pulses; e0 = errPulses;
    sendBits({10'b0, v}, WB);
    sendMarker();
    chk("R8 one pulse per word", pulses, p0 + 1);
    chk("R1 word value", lastWord, v);
    chk("R1 no error on valid word", errPulses, e0);
  endtask

  // R4 R5 R7: discarded span: one error, no pulse, output held
  task automatic badSpan(input string req, input int n);
    int p0, e0;
    logic [WB-1:0] w0;
    p0 = pulses; e0 = errPulses; w0 = wordOut;
    sendBits(32'h2A5C3F1, n);
    sendMarker();
    chk({req, " error pulse"}, errPulses, e0 + 1);
    chk({req, " no word pulse"}, pulses, p0);
    chk("R7 output held", wordOut, w0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R9 reset word", wordOut, 0);
    chk("R9 reset wordClkN", wordClkN, 1);
    chk("R9 reset frameErr", frameErr, 0);
    rst_n = 1'b1;
    idle(3);
    chk("R9 post-reset wordClkN", wordClkN, 1);

    // R6: bits before the first marker are not a word and not an error
    begin
      int p0, e0;
      p0 = pulses; e0 = errPulses;
      sendBits(32'h15, 7);
      sendMarker();
      chk("R6 no pulse at first marker", pulses, p0);
      chk("R6 no error at first marker", errPulses, e0);
    end

    // R1 R2 R3: walking one and walking zero
    for (int i = 0; i < WB; i++) goodWord(WB'(1) << i);
    for (int i = 0; i < WB; i++) goodWord(~(WB'(1) << i));
    goodWord('0);
    goodWord('1);
    goodWord(22'h155555);
    goodWord(22'h2AAAAA);
    for (int i = 0; i < 12; i++) goodWord(WB'(i * 32'h9E3779 + 32'h5A5A5));

    // R4 R5: wrong counts around the nominal length
    goodWord(22'h0ABCDE);
    badSpan("R4 zero bits", 0);
    badSpan("R4 one bit", 1);
    badSpan("R4 21 bits", 21);
    badSpan("R5 23 bits", 23);
    badSpan("R5 30 bits", 30);
    goodWord(22'h3C0FF0);

    // R10: broken marker (long high, short low) with 22 bits total
    begin
      int p0, e0;
      p0 = pulses; e0 = errPulses;
      sendBits(32'h3FF, 10);
      rxClk = 1'b0; idle(HALF);
      rxClk = 1'b1; idle(2 * BC);
      sendBits(32'h0F0, 12);
      sendMarker();
      chk("R10 error on broken marker", errPulses, e0 + 1);
      chk("R10 no word on broken marker", pulses, p0);
      chk("R7 held after broken marker", wordOut, 22'h3C0FF0);
    end
    goodWord(22'h12345);

    // R11: stray long low with 22 bits total
    begin
      int p0, e0;
      p0 = pulses; e0 = errPulses;
      sendBits(32'h155, 10);
      rxClk = 1'b0; idle(2 * BC);
      sendBits(32'hAAA, 12);
      sendMarker();
      chk("R11 error on stray long low", errPulses, e0 + 1);
      chk("R11 no word on stray long low", pulses, p0);
      chk("R7 held after stray low", wordOut, 22'h12345);
    end
    goodWord(22'h3FFFFE);

    finished = 1;
    summary();
    $finish;
  end

endmodule